// File: doc/BRIEF.md
# Cascadable BCD Decade Counter Stage

This block holds one decimal digit in a 4-bit register and steps it through 0 to 9 on rising clock edges. On any edge it can instead take a preset value from four data pins or return to zero. Every register bit is written on the same edge, so all output bits change together.

Two enable pins control counting. `cnt_en` is a plain run/stop input. `chain_en` also gates the counting, and in addition it qualifies the carry output. The carry output is high while the digit reads 9 and `chain_en` is high.

Several stages form a multi-digit counter without extra logic:
- all stages share one clock;
- all `cnt_en` pins are tied to one common enable;
- each stage's `carry_out` drives the `chain_en` of the next more significant stage.

The clear pin acts either at once (asynchronous) or on the next rising edge (synchronous). The parameter `ASYNC_CLEAR` selects which. No data stream passes through this block, so every pin is a plain control or status level with no handshake.

Top module: `decade_stage`

## Requirements
- R1: With `ASYNC_CLEAR`=1, a low `clr_n` drives `q` to 0 at once without waiting for a clock edge. While `clr_n` stays low, `q` remains 0 whatever `ld_n`, the enables and the clock do.
- R2: With `ASYNC_CLEAR`=0, a low `clr_n` leaves `q` unchanged until the next rising edge, and that edge sets `q` to 0.
- R3: If `ld_n` is low and `clr_n` is high at a rising edge, that edge copies `din` into `q` whatever the levels of `cnt_en` and `chain_en`. Clear takes priority over load, load over count, and count over hold.
- R4: If `clr_n` and `ld_n` are high at a rising edge and `cnt_en` and `chain_en` are both high, `q` advances by one. If either enable is low, `q` holds its value.
- R5: A count from 9 gives 0.
- R6: `carry_out` is high exactly when `q` equals 9 and `chain_en` is high. It follows `chain_en` with no clock delay.
- R7: A loaded value from 10 to 15 goes to 0 on the next enabled count, and `carry_out` stays low while `q` holds such a value.
- R8: Changes on `ld_n`, `din` or `cnt_en` between rising edges leave `q` unchanged until the next edge.
- R9: Two stages on one clock form a correct two-digit count from 00 to 99 that then wraps to 00. In this chain both `cnt_en` pins are tied to a common enable, the low stage's `chain_en` is held high, and the low stage's `carry_out` drives the high stage's `chain_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous per `ASYNC_CLEAR` |
| ld_n | input | 1 | Active-low synchronous preset |
| din | input | DIGIT_W | Preset value |
| cnt_en | input | 1 | Count enable that does not affect carry |
| chain_en | input | 1 | Count enable that also qualifies `carry_out` |
| q | output | DIGIT_W | Present digit |
| carry_out | output | 1 | High while `q`=9 and `chain_en` is high |

## Verification
Clear and load can fall in the same cycle, and so can load and an enabled count. The bench holds `ld_n` low together with a low `clr_n`, and also together with both enables high. It judges the result by the priority in R3: the digit must read 0 in the first case and `din` in the second. A mid-cycle clear is applied to an asynchronous instance and to a synchronous instance side by side. This separates an immediate reset from one that waits for the next edge.

// File: rtl/decade_pkg.sv
package decade_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } stage_op_e;
endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
(
  input  logic      clr_n,
  input  logic      ld_n,
  input  logic      cnt_en,
  input  logic      chain_en,
  output stage_op_e op
);
  // Fixed priority: clear, preset, advance, keep.
  always_comb begin
    if (!clr_n)                   op = OP_CLR;
    else if (!ld_n)               op = OP_LOAD;
    else if (cnt_en && chain_en)  op = OP_INC;
    else                          op = OP_HOLD;
  end
endmodule

// File: rtl/decade_next.sv
module decade_next
  import decade_pkg::*;
#(
  parameter int DIGIT_W  = 4,
  parameter int TERMINAL = 9
) (
  input  stage_op_e          op,
  input  logic [DIGIT_W-1:0] cur,
  input  logic [DIGIT_W-1:0] din,
  output logic [DIGIT_W-1:0] nxt
);
  localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(TERMINAL);
  localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

  // Any value at or past the terminal count rolls to zero.
  logic [DIGIT_W-1:0] stepped;
  assign stepped = (cur >= LAST) ? '0 : cur + ONE;

  always_comb begin
    unique case (op)
      OP_CLR:  nxt = '0;
      OP_LOAD: nxt = din;
      OP_INC:  nxt = stepped;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/decade_reg.sv
module decade_reg #(
  parameter int DIGIT_W     = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic [DIGIT_W-1:0] nxt,
  output logic [DIGIT_W-1:0] cur
);
  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cur <= '0;
        else        cur <= nxt;
      end
    end else begin : g_sync
      // The clear reaches the register through nxt as OP_CLR.
      always_ff @(posedge clk) begin
        cur <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/decade_carry.sv
module decade_carry #(
  parameter int DIGIT_W  = 4,
  parameter int TERMINAL = 9
) (
  input  logic [DIGIT_W-1:0] cur,
  input  logic               chain_en,
  output logic               carry_out
);
  localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(TERMINAL);
  assign carry_out = chain_en && (cur == LAST);
endmodule

// File: rtl/decade_stage.sv
module decade_stage
  import decade_pkg::*;
#(
  parameter int DIGIT_W     = 4,
  parameter int TERMINAL    = 9,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic [DIGIT_W-1:0] din,
  input  logic               cnt_en,
  input  logic               chain_en,
  output logic [DIGIT_W-1:0] q,
  output logic               carry_out
);
  stage_op_e          op;
  logic [DIGIT_W-1:0] nxt;

  decade_ctrl u_ctrl (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op)
  );

  decade_next #(.DIGIT_W(DIGIT_W), .TERMINAL(TERMINAL)) u_next (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (nxt)
  );

  decade_reg #(.DIGIT_W(DIGIT_W), .ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .cur   (q)
  );

  decade_carry #(.DIGIT_W(DIGIT_W), .TERMINAL(TERMINAL)) u_carry (
    .cur       (q),
    .chain_en  (chain_en),
    .carry_out (carry_out)
  );
endmodule

// File: rtl/decade_stage_chk.sv
module decade_stage_chk #(
  parameter int DIGIT_W     = 4,
  parameter int TERMINAL    = 9,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input logic               clk,
  input logic               clr_n,
  input logic               ld_n,
  input logic [DIGIT_W-1:0] din,
  input logic               cnt_en,
  input logic               chain_en,
  input logic [DIGIT_W-1:0] q,
  input logic               carry_out
);
  localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(TERMINAL);
  localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

  // R1 R2
  clear_zero_chk: assert property (@(posedge clk)
    !clr_n |=> (q == '0));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (q == $past(din)));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && chain_en && q < LAST) |=> (q == $past(q) + ONE));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(cnt_en && chain_en)) |=> $stable(q));

  // R5 R7
  wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && chain_en && q >= LAST) |=> (q == '0));

  // R6
  carry_qual_chk: assert property (@(posedge clk)
    carry_out |-> (chain_en && q == LAST));
endmodule

bind decade_stage decade_stage_chk #(
  .DIGIT_W(DIGIT_W), .TERMINAL(TERMINAL), .ASYNC_CLEAR(ASYNC_CLEAR)
) u_chk (.*);

// File: tb/sim_decade_stage.sv
`timescale 1ns/100ps
module sim_decade_stage;
  typedef struct {
    logic [3:0] q;
    logic       c;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr_n = 1'b0, ld_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q0, q1;
  logic       c0, c1;

  decade_stage #(.ASYNC_CLEAR(1'b1)) u0 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .cnt_en(cnt_en), .chain_en(chain_en), .q(q0), .carry_out(c0));
  decade_stage #(.ASYNC_CLEAR(1'b0)) u1 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .cnt_en(cnt_en), .chain_en(chain_en), .q(q1), .carry_out(c1));

  // Two-digit chain for R9.
  logic       k_clr_n = 1'b0, run = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_c, hi_c;
  decade_stage u_lo (
    .clk(clk), .clr_n(k_clr_n), .ld_n(1'b1), .din(4'd0),
    .cnt_en(run), .chain_en(1'b1), .q(lo_q), .carry_out(lo_c));
  decade_stage u_hi (
    .clk(clk), .clr_n(k_clr_n), .ld_n(1'b1), .din(4'd0),
    .cnt_en(run), .chain_en(lo_c), .q(hi_q), .carry_out(hi_c));

  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;
  exp_t sb[$];
  logic [3:0] model = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: apply inputs at the falling edge, predict the result of the next rising edge.
  task automatic step(input logic c, input logic l, input logic [3:0] d,
                      input logic p, input logic t);
    exp_t e;
    @(negedge clk);
    clr_n = c; ld_n = l; din = d; cnt_en = p; chain_en = t;
    if (!c)          begin model = 4'd0; e.tag = "R1"; end
    else if (!l)     begin model = d;    e.tag = "R3"; end
    else if (p && t) begin
      e.tag = (model >= 4'd9) ? ((model > 4'd9) ? "R7" : "R5") : "R4";
      model = (model >= 4'd9) ? 4'd0 : model + 4'd1;
    end else         e.tag = "R4";
    e.q = model;
    e.c = t && (model == 4'd9);
    sb.push_back(e);
  endtask

  // Monitor: compare both variants shortly after each rising edge.
  initial forever begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(q0 == e.q, {e.tag, " async q"}, q0, e.q);
      chk(q1 == e.q, {e.tag, " sync q"},  q1, e.q);
      chk(c0 == e.c, "R6 carry", c0, e.c);
    end
  end

  task automatic drain();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // Reset and clear; clear wins over load.
    step(0, 1, 0, 1, 1);
    step(0, 0, 4'd5, 1, 1);
    // Count through the wrap.
    for (int i = 0; i < 12; i++) step(1, 1, 0, 1, 1);
    // Hold with either enable low.
    step(1, 1, 0, 0, 1);
    step(1, 1, 0, 1, 0);
    // Load with enables low, then load with a count also requested.
    step(1, 0, 4'd9, 0, 0);
    step(1, 1, 0, 0, 0);        // q=9, carry must stay low
    step(1, 1, 0, 0, 1);        // carry high, still holding
    step(1, 0, 4'd3, 1, 1);
    // Out-of-range presets.
    step(1, 0, 4'd12, 0, 1);
    step(1, 1, 0, 1, 1);
    step(1, 0, 4'd15, 0, 1);
    step(1, 1, 0, 1, 1);
    step(1, 0, 4'd6, 0, 0);
    drain();

    // R8: mid-cycle changes on ld_n, din and cnt_en do not move q.
    @(posedge clk); #1.2;
    ld_n = 1'b0; din = 4'd2; cnt_en = 1'b1; chain_en = 1'b1;
    #0.5;
    chk(q0 == 4'd6, "R8 mid-cycle", q0, 6);
    ld_n = 1'b1; cnt_en = 1'b0;

    // R1 and R2: mid-cycle clear.
    @(posedge clk); #1.2;
    clr_n = 1'b0;
    #0.3;
    chk(q0 == 4'd0, "R1 immediate clear", q0, 0);
    chk(q1 == 4'd6, "R2 waits for edge", q1, 6);
    @(posedge clk); #0.5;
    chk(q1 == 4'd0, "R2 clear at edge", q1, 0);
    chk(q0 == 4'd0, "R1 held clear", q0, 0);
    clr_n = 1'b1;

    // R9: two-digit chain.
    @(negedge clk); k_clr_n = 1'b1; run = 1'b1;
    for (int i = 1; i <= 105; i++) begin
      @(negedge clk);
      chk(hi_q * 10 + lo_q == i % 100, "R9 chain",
          hi_q * 10 + lo_q, i % 100);
    end
    run = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule